// File: doc/BRIEF.md
# Command Transaction Sequencer

This block is a hardware master that runs a single command exchange with an embedded controller over a byte-wide transmit and receive stream. A one-cycle `start` pulse supplies an opcode, a count of parameter bytes and a count of reply bytes. The sequencer first transmits the opcode and then the parameter bytes from a small parameter buffer. It then takes one acknowledge byte off the receive stream and stores the requested reply bytes in a result buffer. At the end of the exchange it pulses `done`.

Every wait has a poll bound, whether the sequencer is waiting for room to transmit or for a received byte. If the controller stops responding, the exchange ends with `done` and a sticky `timeout` flag is set. The acknowledge byte is held for diagnostics. The first two reply bytes also appear as a 16-bit status word. Typical uses are the two status reads: opcode 0x0C returns event status and opcode 0x11 returns external status, and each takes no parameter bytes and returns two reply bytes. The block does not decode opcodes.

Top module: `cts_sequencer`

## Requirements
- R1: An accepted exchange transmits the opcode first, followed by exactly the requested number of parameter bytes. Parameter byte k is taken from `param_bytes[8k+7:8k]`, with k running upward from 0. One byte is transmitted in each cycle in which `tx_valid` is high.
- R2: After the last transmitted byte, exactly one received byte is popped as the acknowledge. That byte is held on `ack_byte` and is not stored in the result buffer.
- R3: After the acknowledge, exactly the requested number of reply bytes is popped. Reply byte j is stored in `resp_bytes[8j+7:8j]`. Slots that receive no byte read zero, because the result buffer is cleared when an exchange is accepted.
- R4: `status_word[15:8]` equals reply byte 0 and `status_word[7:0]` equals reply byte 1.
- R5: A parameter count or a reply count above MAX_BYTES (8) is treated as MAX_BYTES.
- R6: `tx_valid` is only raised in a cycle where `tx_ready` is high.
- R7: `rx_pop` is only raised in a cycle where `rx_avail` is high.
- R8: A wait that lasts POLL_LIMIT consecutive cycles ends the exchange. In that case `done` pulses and `timeout` is set. `timeout` stays set until the next accepted start.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the byte stream and does not cause a second `done`.
- R10: `busy` is high from the cycle after an accepted start until the end of the exchange. `done` is a one-cycle pulse and occurs when `busy` is low.
- R11: After reset, `busy`, `done`, `timeout`, `tx_valid` and `rx_pop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins an exchange when the block is idle |
| opcode | input | 8 | Command byte |
| in_count | input | REQ_W | Number of parameter bytes |
| out_count | input | REQ_W | Number of reply bytes |
| param_bytes | input | 8*MAX_BYTES | Parameter buffer, byte k at bits 8k+7:8k |
| tx_ready | input | 1 | Transmit stream has space |
| tx_valid | output | 1 | Write strobe for tx_byte |
| tx_byte | output | 8 | Byte being transmitted |
| rx_avail | input | 1 | Receive stream holds a byte |
| rx_byte | input | 8 | Head of the receive stream |
| rx_pop | output | 1 | Consumes rx_byte |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| timeout | output | 1 | Sticky wait-expired flag |
| ack_byte | output | 8 | Last acknowledge byte received |
| resp_bytes | output | 8*MAX_BYTES | Result buffer, reply byte j at bits 8j+7:8j |
| status_word | output | 16 | First two reply bytes combined, first byte in the upper half |

## Verification
A table of exchanges exercises the main path. It covers the two status reads with no parameters, a write with parameters and no reply, a full eight-byte exchange in both directions, and a request above the limit in both counts. Taken together, these separate a wrong byte order, an off-by-one count, a mixed-up acknowledge, a missing clamp and a swapped status half. The receive model always holds spare bytes, so popping too many bytes would be seen. Directed cases then stall each side to reach the poll bound, check the exact expiry time and the stickiness of `timeout`, and send a second start during a stalled exchange.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_ACK  = 2'd2,
    ST_RESP = 2'd3
  } cts_state_e;
endpackage

// File: rtl/cts_wait_timer.sv
module cts_wait_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic ready,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Counts consecutive cycles spent waiting without the awaited handshake.
  always_comb begin
    cnt_en = 1'b1;
    if (!waiting || ready) cnt_d = '0;
    else if (expired)      cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = waiting && !ready && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/cts_result_buf.sv
module cts_result_buf #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           wdata,
  output logic [8*SLOTS-1:0]   data
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_en;

    assign slot_en = clr || (we && (idx == IDX_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= clr ? 8'h00 : wdata;
    end

    assign data[8*g +: 8] = slot_q;
  end
endmodule

// File: rtl/cts_sequencer.sv
module cts_sequencer
  import cts_pkg::*;
#(
  parameter int MAX_BYTES  = 8,
  parameter int REQ_W      = 4,
  parameter int POLL_LIMIT = 10000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [7:0]             opcode,
  input  logic [REQ_W-1:0]       in_count,
  input  logic [REQ_W-1:0]       out_count,
  input  logic [8*MAX_BYTES-1:0] param_bytes,
  input  logic                   tx_ready,
  output logic                   tx_valid,
  output logic [7:0]             tx_byte,
  input  logic                   rx_avail,
  input  logic [7:0]             rx_byte,
  output logic                   rx_pop,
  output logic                   busy,
  output logic                   done,
  output logic                   timeout,
  output logic [7:0]             ack_byte,
  output logic [8*MAX_BYTES-1:0] resp_bytes,
  output logic [15:0]            status_word
);
  localparam int IDX_W = $clog2(MAX_BYTES + 1);
  localparam int SH_W  = BYTE_W * (MAX_BYTES + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  cts_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] n_in_q, n_out_q;
  logic [SH_W-1:0]  sh_q;
  logic             accept, finish, expired, wait_ready;
  logic             done_q, to_q;
  logic [7:0]       ack_q;
  logic [IDX_W-1:0] n_in_eff, n_out_eff;

  assign n_in_eff  = (in_count  > REQ_W'(MAX_BYTES)) ? IDX_W'(MAX_BYTES) : IDX_W'(in_count);
  assign n_out_eff = (out_count > REQ_W'(MAX_BYTES)) ? IDX_W'(MAX_BYTES) : IDX_W'(out_count);

  assign busy     = (state_q != ST_IDLE);
  assign accept   = (state_q == ST_IDLE) && start;
  assign tx_valid = (state_q == ST_SEND) && tx_ready;
  assign rx_pop   = ((state_q == ST_ACK) || (state_q == ST_RESP)) && rx_avail;
  assign tx_byte  = sh_q[7:0];
  assign wait_ready = (state_q == ST_SEND) ? tx_ready : rx_avail;

  cts_wait_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i),
    .waiting(busy),
    .ready  (wait_ready),
    .expired(expired)
  );

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SEND;
        idx_d   = '0;
      end
      ST_SEND: if (tx_valid) begin
        if (idx_q == n_in_q) begin
          state_d = ST_ACK;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else if (expired) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      ST_ACK: if (rx_pop) begin
        if (n_out_q == '0) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else begin
          state_d = ST_RESP;
        end
      end else if (expired) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      ST_RESP: if (rx_pop) begin
        if (idx_q == n_out_q - 1'b1) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else if (expired) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= finish;
      if (accept)                to_q <= 1'b0;
      else if (busy && expired)  to_q <= 1'b1;
    end
  end

  // Command capture and transmit shift register.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      n_in_q  <= '0;
      n_out_q <= '0;
      sh_q    <= '0;
    end else if (accept) begin
      n_in_q  <= n_in_eff;
      n_out_q <= n_out_eff;
      sh_q    <= {param_bytes, opcode};
    end else if (tx_valid) begin
      sh_q    <= sh_q >> BYTE_W;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)                                  ack_q <= '0;
    else if ((state_q == ST_ACK) && rx_pop)      ack_q <= rx_byte;
  end

  cts_result_buf #(.SLOTS(MAX_BYTES), .IDX_W(IDX_W)) u_rbuf (
    .clk  (clk),
    .rst_n(rst_i),
    .clr  (accept),
    .we   ((state_q == ST_RESP) && rx_pop),
    .idx  (idx_q),
    .wdata(rx_byte),
    .data (resp_bytes)
  );

  assign done        = done_q;
  assign timeout     = to_q;
  assign ack_byte    = ack_q;
  assign status_word = {resp_bytes[7:0], resp_bytes[15:8]};
endmodule

// File: rtl/cts_sequencer_chk.sv
module cts_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tx_ready,
  input logic tx_valid,
  input logic rx_avail,
  input logic rx_pop,
  input logic busy,
  input logic done,
  input logic timeout
);
  a_r6_tx_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_ready);

  a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_avail);

  a_r1_phases_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_pop));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_valid && !rx_pop));

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  a_r8_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !(start && !busy)) |=> timeout);
endmodule

bind cts_sequencer cts_sequencer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .tx_ready(tx_ready),
  .tx_valid(tx_valid),
  .rx_avail(rx_avail),
  .rx_pop  (rx_pop),
  .busy    (busy),
  .done    (done),
  .timeout (timeout)
);

// File: tb/cts_sequencer_test.sv
module cts_sequencer_test;
  localparam int MAXB  = 8;
  localparam int LIMIT = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [7:0]        opcode;
  logic [3:0]        in_count, out_count;
  logic [8*MAXB-1:0] param_bytes;
  logic              tx_ready, tx_valid, rx_avail, rx_pop;
  logic [7:0]        tx_byte, rx_byte, ack_byte;
  logic              busy, done, timeout;
  logic [8*MAXB-1:0] resp_bytes;
  logic [15:0]       status_word;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cts_sequencer #(.MAX_BYTES(MAXB), .REQ_W(4), .POLL_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .in_count(in_count), .out_count(out_count), .param_bytes(param_bytes),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .busy(busy), .done(done), .timeout(timeout), .ack_byte(ack_byte),
    .resp_bytes(resp_bytes), .status_word(status_word)
  );

  // Controller model.
  logic       tx_en, rx_en, mclr;
  logic [7:0] rxq [0:15];
  logic [7:0] tx_log [0:31];
  int         rx_len, rx_rd, tx_n, done_cnt;

  assign tx_ready = tx_en;
  assign rx_avail = rx_en && (rx_rd < rx_len);
  assign rx_byte  = (rx_rd < 16) ? rxq[rx_rd] : 8'h00;

  always @(posedge clk) begin
    if (mclr) begin
      tx_n <= 0; rx_rd <= 0; done_cnt <= 0;
    end else begin
      if (tx_valid) begin
        if (tx_n < 32) tx_log[tx_n] <= tx_byte;
        tx_n <= tx_n + 1;
      end
      if (rx_pop) rx_rd <= rx_rd + 1;
      if (done) done_cnt <= done_cnt + 1;
    end
  end

  function automatic logic [7:0] rxv(input logic [7:0] sd, input int i);
    if (i == 0) return ~sd;
    return sd ^ 8'(8'h5A + i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic prep(input [7:0] sd, input int qlen);
    mclr = 1'b1;
    rx_len = qlen;
    for (int i = 0; i < 16; i++) rxq[i] = rxv(sd, i);
    for (int k = 0; k < MAXB; k++) param_bytes[8*k +: 8] = 8'(sd + k);
    @(posedge clk); #1;
    mclr = 1'b0;
  endtask

  task automatic go_wait(input [7:0] op, input [3:0] ni, input [3:0] no, output int cyc);
    opcode = op; in_count = ni; out_count = no; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", 32'(busy), 32'd1);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); #1;
      cyc++;
    end
  endtask

  // {opcode, in count, out count, seed}
  localparam logic [23:0] VEC [0:4] = '{
    24'h0C0210, 24'h11023C, 24'h413070, 24'h408822, 24'h5ACF90
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; start = 1'b0; opcode = '0; in_count = '0; out_count = '0;
    param_bytes = '0; tx_en = 1'b1; rx_en = 1'b1; mclr = 1'b1; rx_len = 0;
    repeat (3) @(posedge clk); #1;
    // R11: reset state
    chk({busy, done, timeout, tx_valid, rx_pop} === 5'b0, "R11 reset outputs",
        32'({busy, done, timeout, tx_valid, rx_pop}), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;

    foreach (VEC[v]) begin
      logic [7:0] op, sd;
      logic [3:0] ni, no;
      int ein, eout;
      bit ok;
      {op, ni, no, sd} = VEC[v];
      ein  = (ni > MAXB) ? MAXB : int'(ni);
      eout = (no > MAXB) ? MAXB : int'(no);
      prep(sd, 11);
      go_wait(op, ni, no, cyc);
      chk(done === 1'b1, "R10 done reached", 32'(done), 32'd1);
      chk(tx_n == 1 + ein, (ni > MAXB) ? "R5 clamped tx count" : "R1 tx count",
          32'(tx_n), 32'(1 + ein));
      ok = (tx_log[0] == op);
      for (int k = 0; k < ein; k++) ok &= (tx_log[k+1] == 8'(sd + k));
      chk(ok, "R1 tx byte order", 32'(tx_log[1]), 32'(8'(sd)));
      chk(ack_byte == rxv(sd, 0), "R2 ack byte", 32'(ack_byte), 32'(rxv(sd, 0)));
      chk(rx_rd == 1 + eout, (no > MAXB) ? "R5 clamped rx count" : "R3 rx count",
          32'(rx_rd), 32'(1 + eout));
      ok = 1'b1;
      for (int j = 0; j < MAXB; j++)
        ok &= (resp_bytes[8*j +: 8] == ((j < eout) ? rxv(sd, j+1) : 8'h00));
      chk(ok, "R3 result slots", resp_bytes[31:0], {rxv(sd,4), rxv(sd,3), rxv(sd,2), rxv(sd,1)});
      if (eout >= 2)
        chk(status_word == {rxv(sd, 1), rxv(sd, 2)}, "R4 status word",
            32'(status_word), 32'({rxv(sd, 1), rxv(sd, 2)}));
      chk(timeout === 1'b0, "R8 no timeout", 32'(timeout), 32'd0);
      @(posedge clk); #1;
      chk(done === 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    end

    // R8: transmit side stalls for good
    prep(8'h33, 11);
    tx_en = 1'b0;
    go_wait(8'h0C, 4'd0, 4'd2, cyc);
    chk(cyc == LIMIT, "R8 tx expiry time", 32'(cyc), 32'(LIMIT));
    chk(timeout === 1'b1, "R8 timeout set", 32'(timeout), 32'd1);
    chk(tx_n == 0, "R8 nothing sent", 32'(tx_n), 32'd0);
    tx_en = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk(timeout === 1'b1, "R8 timeout sticky", 32'(timeout), 32'd1);

    // R8: receive side runs dry after one reply byte
    prep(8'h66, 2);
    go_wait(8'h11, 4'd1, 4'd2, cyc);
    chk(timeout === 1'b1, "R8 rx timeout", 32'(timeout), 32'd1);
    chk(resp_bytes[7:0] == rxv(8'h66, 1), "R3 partial reply kept",
        32'(resp_bytes[7:0]), 32'(rxv(8'h66, 1)));
    chk(resp_bytes[15:8] == 8'h00, "R3 unfilled slot zero", 32'(resp_bytes[15:8]), 32'd0);

    // R8: next start clears the flag
    prep(8'h12, 11);
    go_wait(8'h0C, 4'd0, 4'd2, cyc);
    chk(timeout === 1'b0, "R8 cleared by start", 32'(timeout), 32'd1 - 32'd1);

    // R9: second start during a stalled exchange
    prep(8'h40, 11);
    tx_en = 1'b0;
    opcode = 8'h21; in_count = 4'd1; out_count = 4'd1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (3) @(posedge clk); #1;
    opcode = 8'h99; in_count = 4'd5; out_count = 4'd3; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    tx_en = 1'b1;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); #1;
      cyc++;
    end
    repeat (4) @(posedge clk); #1;
    chk(tx_n == 2 && tx_log[0] == 8'h21 && tx_log[1] == 8'h40, "R9 stream unchanged",
        32'({tx_log[0], tx_log[1]}), 32'h2140);
    chk(done_cnt == 1, "R9 single done", 32'(done_cnt), 32'd1);
    chk(busy === 1'b0, "R9 no second exchange", 32'(busy), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule